// File: doc/BRIEF.md
# Two's Complement Add/Subtract Unit

This block adds or subtracts two operands of a parameterised width with one shared ripple adder. A single mode input chooses the operation. In subtract mode every bit of the second operand is flipped and a carry of one is fed into the lowest stage. The adder therefore forms the first operand plus the negated second operand, because negation is the bitwise inverse plus one.

The block is purely combinational and has no clock or reset. The outputs are the wrapped result, the raw carry out of the top stage and a signed overflow flag. The overflow flag is the exclusive-or of the carry entering the sign stage and the carry leaving it. Signed consumers ignore the carry and read the overflow flag. Unsigned consumers use the carry. After a subtraction the carry is one exactly when no borrow happened, which makes it an unsigned greater-or-equal test.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_sel` = 0, `result` equals (`a_in` + `b_in`) modulo 2^WIDTH.
- R2: With `sub_sel` = 1, `result` equals (`a_in` - `b_in`) modulo 2^WIDTH. It is formed as `a_in` + inverted `b_in` + 1.
- R3: With `sub_sel` = 0, `carry_out` is 1 exactly when the unsigned sum of the operands is 2^WIDTH or more.
- R4: With `sub_sel` = 1, `carry_out` is 1 exactly when `a_in` >= `b_in` taken as unsigned values, that is when no borrow occurs.
- R5: `overflow` is 1 exactly when the true signed result, with both operands read as two's complement, lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. At width 4 the sums 7+2 and -7+(-2) set it, and the sums 7+(-2) and -7+2 leave it clear.
- R6: In subtract mode, overflow is also detected for operand pairs whose signs differ. At width 4, -8-1 and 0-(-8) set `overflow`, and 7-(-1) sets it as well.
- R7: With `a_in` = 0 and `sub_sel` = 1, `result` is the two's complement negation of `b_in`. Negating 0 gives result 0, `carry_out` 1 and `overflow` 0.
- R8: WIDTH is a parameter with a default of 8 and a minimum of 2. All outputs depend only on the present inputs, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand (minuend in subtract mode) |
| b_in | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Wrapped sum or difference |
| carry_out | output | 1 | Carry out of the top stage |
| overflow | output | 1 | Signed overflow |

## Verification
At width 4 the bench covers every operand pair in both modes and compares each output with a signed-integer model. The corner cases it targets are these:
- If the design forgot to inject the carry-in on subtract, every difference would come out one low.
- If it took overflow from the wrong pair of carries, the 7+2 case or the -7+2 case would be misflagged.
- If it inverted the carry in subtract mode, the unsigned greater-or-equal reading would flip.
- Negating the most negative value and negating zero are exercised on purpose. The first must report overflow. The second must report no overflow while the carry is set.

At the default width, directed corners confirm that nothing is tied to width 4.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } mode_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } flags_t;

    // one bit of addition: returns {carry, sum}
    function automatic logic [1:0] bit_add(input logic x, input logic y, input logic cin);
        logic s;
        logic c;
        s = x ^ y ^ cin;
        c = (x & y) | (x & cin) | (y & cin);
        return {c, s};
    endfunction

endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_in,
    input  mode_e            mode,
    output logic [WIDTH-1:0] opnd_out,
    output logic             carry_seed
);
    logic inv;
    assign inv = (mode == MODE_SUB);

    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign opnd_out[i] = opnd_in[i] ^ inv;
    end

    assign carry_seed = inv;
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_top,
    output logic             c_sign_in
);
    logic [WIDTH:0] chain;
    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic [1:0] fa;
        assign fa          = bit_add(x[i], y[i], chain[i]);
        assign sum[i]      = fa[0];
        assign chain[i+1]  = fa[1];
    end

    assign c_top     = chain[WIDTH];
    assign c_sign_in = chain[WIDTH-1];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
(
    input  logic   c_top,
    input  logic   c_sign_in,
    output flags_t flags
);
    assign flags.carry = c_top;
    assign flags.ovf   = c_top ^ c_sign_in;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    mode_e            mode;
    logic [WIDTH-1:0] b_cond;
    logic             seed;
    logic             c_top;
    logic             c_sign_in;
    flags_t           flags;

    assign mode = mode_e'(sub_sel);

    addsub_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .opnd_in    (b_in),
        .mode       (mode),
        .opnd_out   (b_cond),
        .carry_seed (seed)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_ripple (
        .x         (a_in),
        .y         (b_cond),
        .cin       (seed),
        .sum       (result),
        .c_top     (c_top),
        .c_sign_in (c_sign_in)
    );

    addsub_flags u_flags (
        .c_top     (c_top),
        .c_sign_in (c_sign_in),
        .flags     (flags)
    );

    assign carry_out = flags.carry;
    assign overflow  = flags.ovf;

    // behavioural cross-checks against the ripple structure
    logic [WIDTH:0] add_ref;
    logic [WIDTH:0] sub_ref;
    logic           ovf_ref;
    always_comb begin
        add_ref = {1'b0, a_in} + {1'b0, b_in};
        sub_ref = {1'b0, a_in} - {1'b0, b_in};
        if (sub_sel)
            ovf_ref = (a_in[MSB] != b_in[MSB]) && (result[MSB] != a_in[MSB]);
        else
            ovf_ref = (a_in[MSB] == b_in[MSB]) && (result[MSB] != a_in[MSB]);

        if (!$isunknown({a_in, b_in, sub_sel})) begin
            AST_ADD_VALUE: assert (sub_sel || {carry_out, result} == add_ref); // R1 R3
            AST_SUB_VALUE: assert (!sub_sel || result == sub_ref[MSB:0]);     // R2
            AST_SUB_NOBORROW: assert (!sub_sel || carry_out == (a_in >= b_in)); // R4
            AST_SIGNED_OVF: assert (overflow == ovf_ref);                   // R5 R6
        end
    end

    initial begin
        AST_MIN_WIDTH: assert (WIDTH >= 2); // R8
    end
endmodule

// File: tb/tb_addsub_unit.sv
module tb_addsub_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // width-4 instance for exhaustive work
    logic [3:0] a4, b4, r4;
    logic       s4, c4, v4;
    addsub_unit #(.WIDTH(4)) dut (
        .a_in(a4), .b_in(b4), .sub_sel(s4),
        .result(r4), .carry_out(c4), .overflow(v4)
    );

    // default-width instance
    logic [7:0] a8, b8, r8;
    logic       s8, c8, v8;
    addsub_unit dut8 (
        .a_in(a8), .b_in(b8), .sub_sel(s8),
        .result(r8), .carry_out(c8), .overflow(v8)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive4(input int a, input int b, input bit sub);
        a4 = 4'(a); b4 = 4'(b); s4 = sub;
        #1;
    endtask

    // model: full signed and unsigned view of one width-4 operation
    task automatic check4(input int a, input int b, input bit sub, input string tag);
        int ua, ub, sa, sb, full, ures;
        bit cexp;
        ua = a & 15; ub = b & 15;
        sa = (ua > 7) ? ua - 16 : ua;
        sb = (ub > 7) ? ub - 16 : ub;
        full = sub ? sa - sb : sa + sb;
        ures = full & 15;
        cexp = sub ? (ua >= ub) : ((ua + ub) > 15);
        drive4(ua, ub, sub);
        chk({tag, sub ? " R2 result" : " R1 result"}, int'(r4), ures);
        chk({tag, sub ? " R4 carry" : " R3 carry"}, int'(c4), int'(cexp));
        chk({tag, " R5 overflow"}, int'(v4), int'(full > 7 || full < -8));
    endtask

    task automatic t_idle_state;
        drive4(0, 0, 1'b0);
        chk("idle R1 result", int'(r4), 0);
        chk("idle R3 carry", int'(c4), 0);
        chk("idle R5 overflow", int'(v4), 0);
    endtask

    task automatic t_overflow_examples;
        drive4(7, 2, 1'b0);   chk("R5 7+2 ovf", int'(v4), 1);
        drive4(-7, -2, 1'b0); chk("R5 -7+-2 ovf", int'(v4), 1);
        drive4(7, -2, 1'b0);  chk("R5 7+-2 ovf", int'(v4), 0);
        chk("R3 7+-2 carry", int'(c4), 1);
        drive4(-7, 2, 1'b0);  chk("R5 -7+2 ovf", int'(v4), 0);
        chk("R1 -7+2 result", int'(r4), 11);
    endtask

    task automatic t_sub_corners;
        drive4(-8, 1, 1'b1);  chk("R6 -8-1 ovf", int'(v4), 1);
        chk("R6 -8-1 result", int'(r4), 7);
        drive4(0, -8, 1'b1);  chk("R6 0-(-8) ovf", int'(v4), 1);
        chk("R7 0-(-8) result", int'(r4), 8);
        drive4(7, -1, 1'b1);  chk("R6 7-(-1) ovf", int'(v4), 1);
        drive4(0, 0, 1'b1);
        chk("R7 neg0 result", int'(r4), 0);
        chk("R7 neg0 carry", int'(c4), 1);
        chk("R7 neg0 ovf", int'(v4), 0);
        drive4(0, 5, 1'b1);   chk("R7 neg5 result", int'(r4), 11);
        chk("R4 0-5 borrow", int'(c4), 0);
    endtask

    task automatic t_exhaustive4;
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    check4(a, b, bit'(m), "exh");
    endtask

    task automatic t_width8;
        a8 = 8'd127; b8 = 8'd1; s8 = 1'b0; #1;
        chk("R8 w8 127+1 result", int'(r8), 128);
        chk("R8 w8 127+1 ovf", int'(v8), 1);
        chk("R8 w8 127+1 carry", int'(c8), 0);
        a8 = 8'd255; b8 = 8'd1; s8 = 1'b0; #1;
        chk("R8 w8 255+1 result", int'(r8), 0);
        chk("R8 w8 255+1 carry", int'(c8), 1);
        chk("R8 w8 -1+1 ovf", int'(v8), 0);
        a8 = 8'd128; b8 = 8'd1; s8 = 1'b1; #1;
        chk("R8 w8 -128-1 result", int'(r8), 127);
        chk("R8 w8 -128-1 ovf", int'(v8), 1);
        chk("R8 w8 128>=1 carry", int'(c8), 1);
        a8 = 8'd3; b8 = 8'd200; s8 = 1'b1; #1;
        chk("R8 w8 3-200 result", int'(r8), 59);
        chk("R8 w8 3<200 carry", int'(c8), 0);
        chk("R8 w8 3-(-56) ovf", int'(v8), 0);
    endtask

    initial begin
        a4 = '0; b4 = '0; s4 = 1'b0;
        a8 = '0; b8 = '0; s8 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(posedge clk);
        t_idle_state();
        t_overflow_examples();
        t_sub_corners();
        t_exhaustive4();
        t_width8();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule